// File: doc/BRIEF.md
# Edge-Timestamp Capture Unit

This block records when a chosen edge arrives on an asynchronous external pin. The raw pin is resynchronized into the clock domain. An optional debounce stage then lets a new level through only after it has held steady for a run of consecutive samples. An edge detector watches the resulting level for either a rising or a falling transition, as selected.

On a qualifying edge, the block copies a free-running count value into a capture register. It also sets a sticky flag and raises an interrupt request when that is enabled. A mode input shuts capture off entirely while the capture register is being used as the counter's period limit.

The counter lives elsewhere and is supplied through `count_i`. Software-side registers are not part of this block; the enables, polarity and clear strobe arrive as plain inputs.

Top module: `edge_capture_unit`

## Requirements
- R1: After synchronous reset, `cap_o` is 0, `flag_o` is 0 and `irq_o` is 0.
- R2: With `filt_en_i`=0, a pin level first presented before clock edge k loads `cap_o` with the `count_i` value sampled at edge k+2. `flag_o` rises at that same edge and not earlier.
- R3: With `filt_en_i`=1, the same edge loads `cap_o` with the `count_i` value sampled at edge k+6. This is exactly four cycles later than with the filter off.
- R4: With `filt_en_i`=1, a pin pulse lasting fewer than 4 clock cycles causes no capture. A pulse of 4 cycles is captured.
- R5: `edge_rise_i`=1 selects rising edges (0 to 1), and `edge_rise_i`=0 selects falling edges (1 to 0). An edge of the other direction changes neither `cap_o` nor `flag_o`.
- R6: `flag_o` stays set until a cycle with `flag_clr_i`=1 clears it. When a capture and `flag_clr_i` fall on the same edge, the flag ends up set.
- R7: `irq_o` is 1 exactly when `flag_o` is 1 and `irq_en_i` was 1 at the same edge. It updates on the same edge as the flag.
- R8: While `top_mode_i`=1, no capture occurs. `cap_o` holds, and `flag_o` is not set. Pin changes made during that time do not produce a capture after `top_mode_i` returns to 0.
- R9: Toggling `edge_rise_i` while the pin is steady produces no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Asynchronous capture pin |
| count_i | input | CNT_W | Free-running counter value |
| filt_en_i | input | 1 | Enables the debounce filter |
| edge_rise_i | input | 1 | 1 = rising edge, 0 = falling edge |
| top_mode_i | input | 1 | Capture register used as period limit; disables capture |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Clear strobe for the capture flag |
| cap_o | output | CNT_W | Captured count value |
| flag_o | output | 1 | Sticky capture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 16-bit count, two synchronizer stages and a four-sample filter. With these values the latencies are exact: two cycles on the direct path and six through the filter. Pulses of three and four cycles therefore sit on either side of the filter threshold. The fixed filter length also enables the in-RTL property that ties every filter output change to four matching earlier samples.

// File: rtl/edge_capture_pkg.sv
package edge_capture_pkg;
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_pol_e;
endpackage

// File: rtl/ecu_sync.sv
module ecu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ecu_filter.sv
module ecu_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din_i,
  output logic filt_o
);
  localparam int HIST = LEN - 1;

  logic [HIST-1:0] hist_q;
  logic [LEN-1:0]  window;
  logic            all_hi, all_lo;
  logic            filt_q;

  assign window = {hist_q, din_i};
  assign all_hi = &window;
  assign all_lo = ~|window;

  generate
    if (HIST == 1) begin : g_h1
      always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= din_i;
      end
    end else begin : g_hn
      always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= {hist_q[HIST-2:0], din_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         filt_q <= 1'b0;
    else if (all_hi) filt_q <= 1'b1;
    else if (all_lo) filt_q <= 1'b0;
  end

  assign filt_o = filt_q;

  generate
    if (LEN == 4) begin : g_chk4
      // R4: a change of the output follows four agreeing input samples
      assert_filter_run_R4: assert property (@(posedge clk) disable iff (rst)
        (filt_q != $past(filt_q)) |->
          ($past(din_i, 1) == filt_q && $past(din_i, 2) == filt_q &&
           $past(din_i, 3) == filt_q && $past(din_i, 4) == filt_q));
    end
  endgenerate
endmodule

// File: rtl/ecu_edge.sv
module ecu_edge
  import edge_capture_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      lvl_i,
  input  edge_pol_e pol_i,
  output logic      hit_o
);
  logic prev_q;

  // previous level is tracked every cycle, independent of polarity
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl_i;
  end

  assign hit_o = (lvl_i != prev_q) && (lvl_i == logic'(pol_i));
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import edge_capture_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             filt_en_i,
  input  logic             edge_rise_i,
  input  logic             top_mode_i,
  input  logic             irq_en_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic             sync_lvl, filt_lvl, sel_lvl, hit, cap_evt, flag_nxt;
  logic [CNT_W-1:0] cap_q;
  logic             flag_q, irq_q;
  edge_pol_e        pol;

  ecu_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(pin_i), .q_o(sync_lvl));

  ecu_filter #(.LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst(rst), .din_i(sync_lvl), .filt_o(filt_lvl));

  assign sel_lvl = filt_en_i ? filt_lvl : sync_lvl;
  assign pol     = edge_rise_i ? EDGE_RISE : EDGE_FALL;

  ecu_edge u_edge (
    .clk(clk), .rst(rst), .lvl_i(sel_lvl), .pol_i(pol), .hit_o(hit));

  assign cap_evt  = hit && !top_mode_i;
  assign flag_nxt = cap_evt ? 1'b1 : (flag_clr_i ? 1'b0 : flag_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (cap_evt) cap_q <= count_i;
      flag_q <= flag_nxt;
      irq_q  <= flag_nxt && irq_en_i;
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  // R6: flag persists without a clear strobe
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !flag_clr_i) |=> flag_q);

  // R6: capture wins over a simultaneous clear
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> flag_q);

  // R7: an enabled capture raises the request
  assert_irq_raise_R7: assert property (@(posedge clk) disable iff (rst)
    (cap_evt && irq_en_i) |=> irq_o);

  // R8: no load of the capture register in limit mode
  assert_top_hold_R8: assert property (@(posedge clk) disable iff (rst)
    top_mode_i |=> $stable(cap_o));
endmodule

// File: tb/test_edge_capture_unit.sv
module test_edge_capture_unit;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pin = 1'b0;
  logic [CW-1:0] cnt = '0;
  logic          filt_en = 1'b0, rise = 1'b1, topm = 1'b0, ie = 1'b0, clr = 1'b0;
  logic [CW-1:0] cap;
  logic          flag, irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 1'b1;

  edge_capture_unit i_edge_capture_unit (
    .clk(clk), .rst(rst), .pin_i(pin), .count_i(cnt),
    .filt_en_i(filt_en), .edge_rise_i(rise), .top_mode_i(topm),
    .irq_en_i(ie), .flag_clr_i(clr),
    .cap_o(cap), .flag_o(flag), .irq_o(irq));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cap", int'(cap), 0);
    chk("R1 flag", int'(flag), 0);
    chk("R1 irq", int'(irq), 0);
  endtask

  task automatic t_rise_raw();
    int c;
    filt_en = 1'b0; rise = 1'b1; ie = 1'b0;
    @(negedge clk); c = int'(cnt); pin = 1'b1;
    wn(2); chk("R2 flag early", int'(flag), 0);
    wn(1);
    chk("R2 cap", int'(cap), c + 2);
    chk("R2 flag", int'(flag), 1);
    chk("R7 irq off", int'(irq), 0);
    wn(4); chk("R6 sticky", int'(flag), 1);
    clear_flag();
    chk("R6 cleared", int'(flag), 0);
  endtask

  task automatic t_fall();
    int c;
    int old;
    rise = 1'b0;
    @(negedge clk); c = int'(cnt); pin = 1'b0;
    wn(3);
    chk("R5 fall cap", int'(cap), c + 2);
    chk("R5 fall flag", int'(flag), 1);
    clear_flag();
    old = int'(cap);
    @(negedge clk); pin = 1'b1;
    wn(8);
    chk("R5 rise ignored cap", int'(cap), old);
    chk("R5 rise ignored flag", int'(flag), 0);
    @(negedge clk); pin = 1'b0;
    wn(8); clear_flag();
  endtask

  task automatic t_filter();
    int c;
    filt_en = 1'b1; rise = 1'b1;
    wn(8); clear_flag();
    @(negedge clk); c = int'(cnt); pin = 1'b1;
    wn(6); chk("R3 flag early", int'(flag), 0);
    wn(1);
    chk("R3 cap", int'(cap), c + 6);
    chk("R3 flag", int'(flag), 1);
    @(negedge clk); pin = 1'b0;
    wn(10); clear_flag();
  endtask

  task automatic t_glitch();
    int c;
    int old;
    filt_en = 1'b1; rise = 1'b1;
    old = int'(cap);
    @(negedge clk); pin = 1'b1;
    wn(3); pin = 1'b0;
    wn(10);
    chk("R4 short cap", int'(cap), old);
    chk("R4 short flag", int'(flag), 0);
    @(negedge clk); c = int'(cnt); pin = 1'b1;
    wn(4); pin = 1'b0;
    wn(3);
    chk("R4 four cap", int'(cap), c + 6);
    chk("R4 four flag", int'(flag), 1);
    wn(10); clear_flag();
  endtask

  task automatic t_set_wins();
    int c;
    filt_en = 1'b0; rise = 1'b1;
    @(negedge clk); c = int'(cnt); pin = 1'b1;
    wn(2); clr = 1'b1;
    wn(1); clr = 1'b0;
    chk("R6 set wins flag", int'(flag), 1);
    chk("R6 set wins cap", int'(cap), c + 2);
    clear_flag();
    chk("R6 clear after", int'(flag), 0);
    @(negedge clk); pin = 1'b0;
    wn(6);
  endtask

  task automatic t_irq();
    filt_en = 1'b0; rise = 1'b1; ie = 1'b1;
    @(negedge clk); pin = 1'b1;
    wn(2); chk("R7 irq early", int'(irq), 0);
    wn(1);
    chk("R7 irq", int'(irq), 1);
    ie = 1'b0;
    wn(1); chk("R7 irq masked", int'(irq), 0);
    chk("R7 flag kept", int'(flag), 1);
    clear_flag();
    @(negedge clk); pin = 1'b0;
    wn(6);
  endtask

  task automatic t_top();
    int old;
    filt_en = 1'b0; rise = 1'b1;
    old = int'(cap);
    @(negedge clk); topm = 1'b1; pin = 1'b1;
    wn(8);
    chk("R8 cap held", int'(cap), old);
    chk("R8 flag", int'(flag), 0);
    topm = 1'b0;
    wn(8);
    chk("R8 release cap", int'(cap), old);
    chk("R8 release flag", int'(flag), 0);
  endtask

  task automatic t_polswitch();
    int old;
    old = int'(cap);
    @(negedge clk); rise = 1'b0;
    wn(4); rise = 1'b1;
    wn(4);
    chk("R9 cap", int'(cap), old);
    chk("R9 flag", int'(flag), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_rise_raw();
    t_fall();
    t_filter();
    t_glitch();
    t_set_wins();
    t_irq();
    t_top();
    t_polswitch();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule